// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block resolves a physical address to one of a fixed set of memory rows. Each row owns a programmable boundary register that holds the row's cumulative upper address limit, counted in 8 MB units. A row starts where the row below it ends, and row 0 starts at address zero. A row that repeats the previous limit holds no memory and is skipped. A zero boundary that follows a nonzero limit stands for the 2 GB top of memory. Each row also carries one bit that tells whether error checking is fitted on that row.

A lookup is presented with `addr_valid`. One clock later the block returns whether the address fell inside a populated row, the index of that row, and the row's error-check bit. A separate query port reports the base, the limit and the empty flag of any row, also one clock later. A single write port loads both the boundary values and the error-check bits.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every boundary value and every error-check bit is zero, so every address misses. `dec_valid`, `dec_hit`, `dec_row`, `dec_ecc`, `qry_base` and `qry_limit` read zero, and `qry_empty` reads one.
- R2: A write with `cfg_we`=1 and `cfg_tgt`=0 stores `cfg_wdata` as the boundary of row `cfg_idx`. A lookup or query presented in the same cycle as the write still sees the old value. One presented in the next cycle sees the new value.
- R3: A row's limit is its boundary value shifted left by 23 bits. Its base is the limit of the row below it, and row 0's base is zero.
- R4: A boundary value of zero whose row's base is nonzero gives a limit of 0x8000_0000 (2 GB).
- R5: A row whose limit is not above its base is empty and never matches. Its query reports `qry_empty`=1.
- R6: A lookup hits when base <= address < limit for some row. When several rows qualify, the lowest index wins. An address outside every row gives `dec_hit`=0, `dec_row`=0 and `dec_ecc`=0.
- R7: `dec_valid` equals `addr_valid` of the previous cycle. When `addr_valid` was 0, `dec_hit`, `dec_row` and `dec_ecc` are 0.
- R8: A write with `cfg_tgt`=1 stores `cfg_wdata[0]` as the error-check bit of row `cfg_idx`. On a hit, `dec_ecc` is the bit of the selected row.
- R9: `qry_base`, `qry_limit` and `qry_empty` describe the row given by `qry_row` in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_tgt | input | 1 | Write target: 0 = boundary value, 1 = error-check bit |
| cfg_idx | input | IDX_W | Row addressed by the write |
| cfg_wdata | input | BND_W | Write data; bit 0 only for an error-check write |
| addr_valid | input | 1 | A lookup address is present |
| addr | input | ADDR_W | Physical address to look up |
| dec_valid | output | 1 | Lookup result valid |
| dec_hit | output | 1 | The address lies in a populated row |
| dec_row | output | IDX_W | Index of the matching row |
| dec_ecc | output | 1 | Error-check bit of the matching row |
| qry_row | input | IDX_W | Row to report on the query port |
| qry_base | output | LIM_W | Base address of the queried row |
| qry_limit | output | LIM_W | Limit address of the queried row |
| qry_empty | output | 1 | The queried row holds no addresses |

## Verification
A boundary write and a lookup can land in the same cycle, and the lookup must be resolved against the old table. The bench provokes this by writing row 0 while it looks up an address that the new value moves from row 2 into row 0. It expects the old row first and the new row on the following cycle. Random traffic keeps these collisions going throughout the run. A behavioural model resolves every lookup and query from the table as it stood before that edge's write and is compared on every clock.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

   // Target selector of the configuration write port.
   typedef enum logic {
      CFG_BOUND = 1'b0,
      CFG_ECC   = 1'b1
   } cfg_tgt_e;

   // Smallest row count the decoder accepts.
   localparam int RDEC_MIN_ROWS = 2;

endpackage

// File: rtl/rdec_cfg_regs.sv
module rdec_cfg_regs
   import rdec_pkg::*;
#(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 8,
   parameter int IDX_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  cfg_tgt_e                  cfg_tgt,
   input  logic [IDX_W-1:0]          cfg_idx,
   input  logic [BND_W-1:0]          cfg_wdata,
   output logic [NUM_ROWS*BND_W-1:0] bnd_flat,
   output logic [NUM_ROWS-1:0]       ecc_vec
);

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic             sel;
      logic [BND_W-1:0] bnd_q;
      logic             ecc_q;

      assign sel = cfg_we && (cfg_idx == IDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bnd_q <= '0;
         end else if (sel && (cfg_tgt == CFG_BOUND)) begin
            bnd_q <= cfg_wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ecc_q <= 1'b0;
         end else if (sel && (cfg_tgt == CFG_ECC)) begin
            ecc_q <= cfg_wdata[0];
         end
      end

      assign bnd_flat[r*BND_W +: BND_W] = bnd_q;
      assign ecc_vec[r]                 = ecc_q;
   end

   AST_BOUND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_tgt == CFG_BOUND && int'(cfg_idx) < NUM_ROWS)
      |=> (bnd_flat[$past(cfg_idx)*BND_W +: BND_W] == $past(cfg_wdata))); // R2

   AST_ECC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_tgt == CFG_ECC && int'(cfg_idx) < NUM_ROWS)
      |=> (ecc_vec[$past(cfg_idx)] == $past(cfg_wdata[0]))); // R8

endmodule

// File: rtl/rdec_limit_chain.sv
module rdec_limit_chain #(
   parameter int NUM_ROWS   = 8,
   parameter int BND_W      = 8,
   parameter int UNIT_SHIFT = 23,
   parameter int LIM_W      = BND_W + UNIT_SHIFT + 1
) (
   input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
   output logic [NUM_ROWS*LIM_W-1:0] base_flat,
   output logic [NUM_ROWS*LIM_W-1:0] lim_flat,
   output logic [NUM_ROWS-1:0]       empty_vec
);

   localparam logic [LIM_W-1:0] TOP_LIM = LIM_W'(1) << (BND_W + UNIT_SHIFT);

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic [LIM_W-1:0] raw_w;
      logic [LIM_W-1:0] base_w;
      logic [LIM_W-1:0] lim_w;

      assign raw_w = LIM_W'(bnd_flat[r*BND_W +: BND_W]) << UNIT_SHIFT;

      if (r == 0) begin : g_first
         assign base_w = '0;
      end else begin : g_next
         assign base_w = g_row[r-1].lim_w;
      end

      // A zero above a populated row wraps to the top of memory.
      assign lim_w = ((raw_w == '0) && (base_w != '0)) ? TOP_LIM : raw_w;

      assign empty_vec[r]               = (lim_w <= base_w);
      assign base_flat[r*LIM_W +: LIM_W] = base_w;
      assign lim_flat[r*LIM_W +: LIM_W]  = lim_w;
   end

endmodule

// File: rtl/rdec_match.sv
module rdec_match #(
   parameter int NUM_ROWS = 8,
   parameter int LIM_W    = 32,
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 3
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_ROWS*LIM_W-1:0] base_flat,
   input  logic [NUM_ROWS*LIM_W-1:0] lim_flat,
   output logic                      hit,
   output logic [IDX_W-1:0]          row
);

   localparam int CMP_W = (ADDR_W > LIM_W) ? ADDR_W : LIM_W;

   logic [CMP_W-1:0]    addr_ext;
   logic [NUM_ROWS-1:0] in_rng;

   assign addr_ext = CMP_W'(addr);

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cmp
      logic [CMP_W-1:0] lo_ext;
      logic [CMP_W-1:0] hi_ext;
      assign lo_ext    = CMP_W'(base_flat[r*LIM_W +: LIM_W]);
      assign hi_ext    = CMP_W'(lim_flat[r*LIM_W +: LIM_W]);
      assign in_rng[r] = (addr_ext >= lo_ext) && (addr_ext < hi_ext);
   end

   // Lowest index wins: scan downward so the last assignment is the lowest.
   always_comb begin
      hit = |in_rng;
      row = '0;
      for (int r = NUM_ROWS - 1; r >= 0; r--) begin
         if (in_rng[r]) begin
            row = IDX_W'(r);
         end
      end
   end

endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
   import rdec_pkg::*;
#(
   parameter int NUM_ROWS   = 8,
   parameter int BND_W      = 8,
   parameter int UNIT_SHIFT = 23,
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = $clog2(NUM_ROWS),
   parameter int LIM_W      = BND_W + UNIT_SHIFT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_tgt,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [BND_W-1:0]  cfg_wdata,
   input  logic              addr_valid,
   input  logic [ADDR_W-1:0] addr,
   output logic              dec_valid,
   output logic              dec_hit,
   output logic [IDX_W-1:0]  dec_row,
   output logic              dec_ecc,
   input  logic [IDX_W-1:0]  qry_row,
   output logic [LIM_W-1:0]  qry_base,
   output logic [LIM_W-1:0]  qry_limit,
   output logic              qry_empty
);

   if (NUM_ROWS < RDEC_MIN_ROWS) begin : g_bad_rows
      $fatal(1, "NUM_ROWS below minimum");
   end
   if (IDX_W != $clog2(NUM_ROWS)) begin : g_bad_idx
      $fatal(1, "IDX_W must be clog2(NUM_ROWS)");
   end
   if (LIM_W != BND_W + UNIT_SHIFT + 1) begin : g_bad_lim
      $fatal(1, "LIM_W must hold the top-of-memory limit");
   end

   logic [NUM_ROWS*BND_W-1:0] bnd_flat;
   logic [NUM_ROWS-1:0]       ecc_vec;
   logic [NUM_ROWS*LIM_W-1:0] base_flat;
   logic [NUM_ROWS*LIM_W-1:0] lim_flat;
   logic [NUM_ROWS-1:0]       empty_vec;
   logic                      hit_c;
   logic [IDX_W-1:0]          row_c;
   logic                      take_c;

   rdec_cfg_regs #(
      .NUM_ROWS (NUM_ROWS),
      .BND_W    (BND_W),
      .IDX_W    (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_tgt   (cfg_tgt_e'(cfg_tgt)),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .bnd_flat  (bnd_flat),
      .ecc_vec   (ecc_vec)
   );

   rdec_limit_chain #(
      .NUM_ROWS   (NUM_ROWS),
      .BND_W      (BND_W),
      .UNIT_SHIFT (UNIT_SHIFT),
      .LIM_W      (LIM_W)
   ) u_chain (
      .bnd_flat  (bnd_flat),
      .base_flat (base_flat),
      .lim_flat  (lim_flat),
      .empty_vec (empty_vec)
   );

   rdec_match #(
      .NUM_ROWS (NUM_ROWS),
      .LIM_W    (LIM_W),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) u_match (
      .addr      (addr),
      .base_flat (base_flat),
      .lim_flat  (lim_flat),
      .hit       (hit_c),
      .row       (row_c)
   );

   assign take_c = addr_valid && hit_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_hit   <= 1'b0;
         dec_row   <= '0;
         dec_ecc   <= 1'b0;
      end else begin
         dec_valid <= addr_valid;
         dec_hit   <= take_c;
         dec_row   <= take_c ? row_c : '0;
         dec_ecc   <= take_c && ecc_vec[row_c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qry_base  <= '0;
         qry_limit <= '0;
         qry_empty <= 1'b1;
      end else begin
         qry_base  <= base_flat[qry_row*LIM_W +: LIM_W];
         qry_limit <= lim_flat[qry_row*LIM_W +: LIM_W];
         qry_empty <= empty_vec[qry_row];
      end
   end

   AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> dec_valid); // R7

   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> (!dec_valid && !dec_hit && !dec_ecc)); // R7

   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (dec_row == '0 && !dec_ecc)); // R6

   AST_HIT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      take_c |-> !empty_vec[row_c]); // R5

   AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> dec_valid); // R7

endmodule

// File: tb/tb_dram_row_decoder.sv
module tb_dram_row_decoder;

   localparam int ROWS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_tgt = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        addr_valid = 1'b0;
   logic [31:0] addr = '0;
   logic        dec_valid;
   logic        dec_hit;
   logic [2:0]  dec_row;
   logic        dec_ecc;
   logic [2:0]  qry_row = '0;
   logic [31:0] qry_base;
   logic [31:0] qry_limit;
   logic        qry_empty;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   dram_row_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .addr_valid(addr_valid),
      .addr(addr), .dec_valid(dec_valid), .dec_hit(dec_hit),
      .dec_row(dec_row), .dec_ecc(dec_ecc), .qry_row(qry_row),
      .qry_base(qry_base), .qry_limit(qry_limit), .qry_empty(qry_empty)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int unsigned m_bnd [ROWS];
   bit          m_ecc [ROWS];
   bit          e_valid, e_hit, e_ecc, e_empty;
   int          e_row;
   longint      e_base, e_lim;
   bit          armed = 0;

   function automatic longint ref_lim(int r);
      longint prev = 0;
      longint cur = 0;
      for (int i = 0; i <= r; i++) begin
         cur = longint'(m_bnd[i]) << 23;
         if (cur == 0 && prev != 0) cur = 64'h8000_0000;
         prev = cur;
      end
      return cur;
   endfunction

   function automatic longint ref_base(int r);
      return (r == 0) ? 0 : ref_lim(r - 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ROWS; i++) begin
            m_bnd[i] = 0;
            m_ecc[i] = 0;
         end
         e_valid = 0; e_hit = 0; e_ecc = 0; e_row = 0;
         e_base = 0; e_lim = 0; e_empty = 1;
      end else begin
         e_valid = addr_valid;
         e_hit = 0; e_row = 0; e_ecc = 0;
         if (addr_valid) begin
            for (int i = 0; i < ROWS; i++) begin
               if (!e_hit && longint'(addr) >= ref_base(i) && longint'(addr) < ref_lim(i)) begin
                  e_hit = 1; e_row = i; e_ecc = m_ecc[i];
               end
            end
         end
         e_base  = ref_base(int'(qry_row));
         e_lim   = ref_lim(int'(qry_row));
         e_empty = (e_lim <= e_base);
         if (cfg_we) begin
            if (cfg_tgt) m_ecc[cfg_idx] = cfg_wdata[0];
            else         m_bnd[cfg_idx] = cfg_wdata;
         end
         armed = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && armed) begin
         chk("R7 dec_valid", 64'(dec_valid), 64'(e_valid));
         chk("R6 hit/row", {dec_hit, 60'(dec_row)}, {e_hit, 60'(e_row)});
         chk("R8 dec_ecc", 64'(dec_ecc), 64'(e_ecc));
         chk("R9 query", {qry_empty, qry_base, 31'(qry_limit)},
             {e_empty, 32'(e_base), 31'(e_lim)});
      end
   end

   // ---------------- directed helpers ----------------
   task automatic wr(input bit tgt, input int idx, input int data);
      @(negedge clk);
      cfg_we = 1; cfg_tgt = tgt; cfg_idx = 3'(idx); cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic look(input logic [31:0] a, input bit h, input int r, input bit e, input string tag);
      @(negedge clk);
      addr_valid = 1; addr = a;
      @(negedge clk);
      addr_valid = 0;
      chk(tag, {dec_valid, dec_hit, 3'(dec_row), dec_ecc}, {1'b1, h, 3'(r), e});
   endtask

   task automatic ask(input int r, input longint b, input longint l, input bit em, input string tag);
      @(negedge clk);
      qry_row = 3'(r);
      @(negedge clk);
      chk(tag, {qry_empty, qry_base, qry_limit}, {em, 32'(b), 32'(l)});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk("R1 reset outputs", {dec_valid, dec_hit, 3'(dec_row), dec_ecc},  '0);
      chk("R1 reset query", {qry_empty, qry_base, qry_limit}, {1'b1, 64'h0});
      look(32'h0, 0, 0, 0, "R1 miss after reset");

      // table: 2,2,6,6,0x10,0,0,0 ; error-check bits on rows 0,2,5
      wr(0, 0, 2);  wr(0, 1, 2);  wr(0, 2, 6);  wr(0, 3, 6);
      wr(0, 4, 16); wr(0, 5, 0);  wr(0, 6, 0);  wr(0, 7, 0);
      wr(1, 0, 1);  wr(1, 2, 1);  wr(1, 5, 1);  wr(1, 4, 8'hFE);

      ask(0, 0, 64'h0100_0000, 0, "R3 row0 base zero");
      ask(2, 64'h0100_0000, 64'h0300_0000, 0, "R3 row2 base/limit");
      ask(5, 64'h0800_0000, 64'h8000_0000, 0, "R4 row5 top of memory");
      ask(1, 64'h0100_0000, 64'h0100_0000, 1, "R5 row1 empty");
      ask(6, 64'h8000_0000, 64'h8000_0000, 1, "R5 row6 empty after top");

      look(32'h0000_0000, 1, 0, 1, "R6 row0 low");
      look(32'h00FF_FFFF, 1, 0, 1, "R6 row0 high");
      look(32'h0100_0000, 1, 2, 1, "R6 skip empty row1");
      look(32'h0300_0000, 1, 4, 0, "R8 row4 bit cleared");
      look(32'h0800_0000, 1, 5, 1, "R4 row5 start");
      look(32'h7FFF_FFFF, 1, 5, 1, "R4 row5 last byte");
      look(32'h8000_0000, 0, 0, 0, "R6 above top");
      look(32'hFFFF_FFFF, 0, 0, 0, "R6 far above top");

      // R2: write and lookup in the same cycle
      @(negedge clk);
      cfg_we = 1; cfg_tgt = 0; cfg_idx = 3'd0; cfg_wdata = 8'd4;
      addr_valid = 1; addr = 32'h0180_0000;
      @(negedge clk);
      cfg_we = 0;
      chk("R2 same cycle uses old", {dec_hit, 3'(dec_row)}, {1'b1, 3'd2});
      @(negedge clk);
      addr_valid = 0;
      chk("R2 next cycle uses new", {dec_hit, 3'(dec_row), dec_ecc}, {1'b1, 3'd0, 1'b1});

      // R5: row1 limit now below its base
      ask(1, 64'h0200_0000, 64'h0100_0000, 1, "R5 row1 inverted");
      look(32'h0100_0000, 1, 0, 1, "R5 inverted row never wins");

      // R6: empty row 0, row1 takes over from zero
      wr(0, 0, 0);
      look(32'h0000_0000, 1, 1, 0, "R6 row0 empty skipped");
      ask(0, 0, 0, 1, "R5 row0 empty");

      // random traffic with colliding writes, checked by the model
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         cfg_we     = ($urandom_range(0, 3) == 0);
         cfg_tgt    = $urandom_range(0, 1) == 1;
         cfg_idx    = 3'($urandom_range(0, 7));
         cfg_wdata  = ($urandom_range(0, 4) == 0) ? 8'd0 : 8'($urandom_range(0, 255));
         addr_valid = $urandom_range(0, 3) != 0;
         addr       = ($urandom_range(0, 1) == 1) ? 32'($urandom) : 32'($urandom) >> 4;
         qry_row    = 3'($urandom_range(0, 7));
      end
      @(negedge clk);
      cfg_we = 0; addr_valid = 0;
      repeat (2) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule